// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

The block is a 16-bit periodic interval timer. A reload register holds the start value, and a down counter steps by one on each pulse of an external tick. The tick is a clock enable that arrives already selected and divided, so the block does no clock selection or prescaling. When the count reaches zero, a sticky terminal-count flag is set. On the next tick the counter reloads, so the flag is raised once every reload+1 ticks. Software can force a reload on the next tick with a self-clearing restart bit.

Software reaches the block through a byte-wide register port with separate write and read strobes. It holds a control/status byte and the reload value, and it can read back the live count. Reading the control/status byte clears the terminal-count flag, but not while the debug freeze input is high. The freeze input stops the counter only when the freeze-enable bit is set. The interrupt output follows the flag while interrupts are enabled.

The counter is run by a three-state machine:
- `ST_DOWN` means the count is nonzero and decrementing. On a tick with count 1 it moves to `ST_ZERO`.
- `ST_ZERO` means the count is zero. The next tick loads the reload value and moves to `ST_DOWN`, or stays in `ST_ZERO` when the reload value is zero.
- `ST_RELOAD` means a restart is pending. The next tick loads the reload value and leaves the same way as `ST_ZERO`.
- A restart write moves the machine from any state to `ST_RELOAD`.

Top module: `ivt_timer`

Register map (byte address on `wr_addr`/`rd_addr`):

| Address | Contents |
|---|---|
| 0 | control/status byte (bits listed in R4 to R8) |
| 1 | reload value, low byte |
| 2 | reload value, high byte |
| 3 | live count, low byte (read-only) |
| 4 | live count, high byte (read-only) |

## Requirements
- R1: After reset, the control/status byte reads 0x00 and `irq` is low. The reload value and the count both read 0xFFFF.
- R2: Each clock cycle with `tick` high and the timer not frozen lowers the count by one. Without a tick the count holds.
- R3: The tick that brings the count to zero sets the terminal-count flag, which reads as bit 1 of address 0. The following tick loads the reload value.
- R4: Writing address 0 with bit 0 set marks a restart pending, which reads back as bit 0 = 1. The next unfrozen tick loads the reload value and clears bit 0. Writing bit 0 as 0 does nothing.
- R5: Bit 1 of address 0 is read-only. Writing it leaves the flag unchanged.
- R6: A read strobe on address 0 returns the flag as it stood, then clears it, provided `freeze` is low. With `freeze` high, the flag stays set after the read.
- R7: `irq` is high exactly while the flag is set and the interrupt enable (bit 2 of address 0) is 1.
- R8: When freeze-enable (bit 3 of address 0) is 1 and `freeze` is high, ticks have no effect, and a pending restart waits for them. When freeze-enable is 0, `freeze` does not stop the counter.
- R9: Writing the reload bytes does not change the live count. The new value takes effect at the next reload.
- R10: With a reload value of zero, every unfrozen tick leaves the count at zero and sets the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | One-cycle read strobe, which clears the flag on a status read |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| tick | input | 1 | Count enable, one pulse per timer step |
| freeze | input | 1 | Debug freeze request |
| irq | output | 1 | Interrupt request level |

## Verification
The bench goes after the count's arrival at zero and the reload on the next tick. A design that reloaded too early would never show a zero count, and one that set the flag a tick late would miss the read that follows. A status read is issued while `freeze` is high, where a design that ignored freeze would drop the flag and the interrupt. The bench freezes the timer with a restart pending, where a design that let the restart bypass the freeze would load the reload value too soon. It also loads a zero reload value, where a design that treats zero like any other value would set the flag only once.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    // Register byte addresses (reload and count bytes follow the status byte)
    localparam int unsigned ADR_CSR = 0;
    localparam int unsigned ADR_RLD = 1;

    // Control/status bit positions
    localparam int unsigned CSR_RESTART = 0;
    localparam int unsigned CSR_TC      = 1;
    localparam int unsigned CSR_IE      = 2;
    localparam int unsigned CSR_FRZEN   = 3;

    typedef enum logic [1:0] {
        ST_DOWN   = 2'd0,
        ST_ZERO   = 2'd1,
        ST_RELOAD = 2'd2
    } cnt_state_e;

endpackage

// File: rtl/ivt_reload.sv
module ivt_reload #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  reload
);
    import ivt_pkg::*;

    localparam int unsigned NBYTES = CNT_W / DATA_W;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic [DATA_W-1:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '1;
            end else if (wr_en && wr_addr == ADDR_W'(ADR_RLD + b)) begin
                byte_q <= wr_data;
            end
        end
        assign reload[b*DATA_W +: DATA_W] = byte_q;
    end

endmodule

// File: rtl/ivt_csr.sv
module ivt_csr #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              freeze,
    input  logic              zero_evt,
    input  logic              pend,
    output logic              restart_req,
    output logic              ie,
    output logic              frz_en,
    output logic              tc,
    output logic [DATA_W-1:0] csr_byte
);
    import ivt_pkg::*;

    logic csr_wr;
    logic csr_rd_clr;

    assign csr_wr      = wr_en && (wr_addr == ADDR_W'(ADR_CSR));
    assign csr_rd_clr  = rd_en && (rd_addr == ADDR_W'(ADR_CSR)) && !freeze;
    assign restart_req = csr_wr && wr_data[CSR_RESTART];

    // Enable bits: plain read/write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie     <= 1'b0;
            frz_en <= 1'b0;
        end else if (csr_wr) begin
            ie     <= wr_data[CSR_IE];
            frz_en <= wr_data[CSR_FRZEN];
        end
    end

    // Sticky flag: a zero event wins over a clearing read in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc <= 1'b0;
        end else if (zero_evt) begin
            tc <= 1'b1;
        end else if (csr_rd_clr) begin
            tc <= 1'b0;
        end
    end

    always_comb begin
        csr_byte              = '0;
        csr_byte[CSR_RESTART] = pend;
        csr_byte[CSR_TC]      = tc;
        csr_byte[CSR_IE]      = ie;
        csr_byte[CSR_FRZEN]   = frz_en;
    end

endmodule

// File: rtl/ivt_count_fsm.sv
module ivt_count_fsm #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_eff,
    input  logic             restart_req,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             pend,
    output logic             zero_evt
);
    import ivt_pkg::*;

    cnt_state_e state_q, state_d;
    logic       do_load;
    logic       do_dec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DOWN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        do_load  = 1'b0;
        do_dec   = 1'b0;
        zero_evt = 1'b0;
        unique case (state_q)
            ST_DOWN: begin
                if (tick_eff) begin
                    do_dec = 1'b1;
                    if (cnt == CNT_W'(1)) begin
                        zero_evt = 1'b1;
                        state_d  = ST_ZERO;
                    end
                end
            end
            ST_ZERO, ST_RELOAD: begin
                if (tick_eff) begin
                    do_load = 1'b1;
                    if (reload == '0) begin
                        zero_evt = 1'b1;
                        state_d  = ST_ZERO;
                    end else begin
                        state_d  = ST_DOWN;
                    end
                end
            end
            default: state_d = ST_DOWN;
        endcase
        if (restart_req) begin
            state_d = ST_RELOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '1;
        end else if (do_load) begin
            cnt <= reload;
        end else if (do_dec) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign pend = (state_q == ST_RELOAD);

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick,
    input  logic              freeze,
    output logic              irq
);
    import ivt_pkg::*;

    localparam int unsigned NBYTES  = CNT_W / DATA_W;
    localparam int unsigned ADR_CNT = ADR_RLD + NBYTES;

    logic [CNT_W-1:0]  reload_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [DATA_W-1:0] csr_byte_w;
    logic              tc_w, ie_w, frzen_w, pend_w;
    logic              restart_req_w, zero_evt_w, tick_eff_w;

    assign tick_eff_w = tick && !(frzen_w && freeze);

    ivt_reload #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_reload (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .reload  (reload_w)
    );

    ivt_csr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .freeze      (freeze),
        .zero_evt    (zero_evt_w),
        .pend        (pend_w),
        .restart_req (restart_req_w),
        .ie          (ie_w),
        .frz_en      (frzen_w),
        .tc          (tc_w),
        .csr_byte    (csr_byte_w)
    );

    ivt_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_eff    (tick_eff_w),
        .restart_req (restart_req_w),
        .reload      (reload_w),
        .cnt         (cnt_w),
        .pend        (pend_w),
        .zero_evt    (zero_evt_w)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADR_CSR)) begin
            rd_data = csr_byte_w;
        end
        for (int b = 0; b < NBYTES; b++) begin
            if (rd_addr == ADDR_W'(ADR_RLD + b)) begin
                rd_data = reload_w[b*DATA_W +: DATA_W];
            end
            if (rd_addr == ADDR_W'(ADR_CNT + b)) begin
                rd_data = cnt_w[b*DATA_W +: DATA_W];
            end
        end
    end

    assign irq = tc_w && ie_w;

endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              freeze,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  reload,
    input logic              tc,
    input logic              frz_en,
    input logic              pend
);
    logic tick_live;
    assign tick_live = tick && !(frz_en && freeze);

    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_live && !pend && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

    p_flag_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_live && !pend && cnt == CNT_W'(1)) |=> tc);

    p_restart_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_live && pend) |=> cnt == $past(reload));

    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == '0 && !freeze && !tick) |=> !irq);

    p_frozen_read_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == '0 && freeze && tc) |=> tc);

    p_frozen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_en && freeze) |=> $stable(cnt));

endmodule

bind ivt_timer ivt_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .freeze  (freeze),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .irq     (irq),
    .cnt     (cnt_w),
    .reload  (reload_w),
    .tc      (tc_w),
    .frz_en  (frzen_w),
    .pend    (pend_w)
);

// File: tb/ivt_timer_test.sv
module ivt_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tick = 1'b0;
    logic       freeze = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    ivt_timer uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick(tick), .freeze(freeze), .irq(irq)
    );

    // Monitor: pops one expected byte per read strobe
    always @(negedge clk) begin
        if (rd_en && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_data !== e) begin
                errors++;
                $display("FAIL %s addr=%0d actual=%02h expected=%02h", t, rd_addr, rd_data, e);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_en = 1'b1; rd_addr = a;
        cyc();
        rd_en = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            cyc();
        end
        tick = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
        end
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        chk_irq(1'b0, "R1");
        rd(0, 8'h00, "R1");
        rd(1, 8'hFF, "R1");
        rd(2, 8'hFF, "R1");
        rd(3, 8'hFF, "R1");
        rd(4, 8'hFF, "R1");

        // R9 reload write leaves the count alone
        wr(1, 8'h05);
        wr(2, 8'h00);
        rd(3, 8'hFF, "R9");
        rd(4, 8'hFF, "R9");

        // R4 restart pending then applied on the tick
        wr(0, 8'h01);
        rd(0, 8'h01, "R4");
        cyc();
        rd(0, 8'h01, "R4");
        pulse(1);
        rd(0, 8'h00, "R4");
        rd(3, 8'h05, "R4");
        rd(4, 8'h00, "R4");

        // R2 decrement and hold
        pulse(3);
        rd(3, 8'h02, "R2");
        repeat (4) cyc();
        rd(3, 8'h02, "R2");
        wr(0, 8'h00);
        rd(3, 8'h02, "R4");

        // R3 reach zero, flag, reload
        pulse(2);
        rd(3, 8'h00, "R3");
        chk_irq(1'b0, "R7");
        rd(0, 8'h02, "R3");
        rd(0, 8'h00, "R6");
        pulse(1);
        rd(3, 8'h05, "R3");

        // R7 interrupt
        wr(0, 8'h04);
        rd(0, 8'h04, "R7");
        pulse(4);
        chk_irq(1'b0, "R7");
        pulse(1);
        chk_irq(1'b1, "R7");

        // R6 read under freeze keeps the flag
        freeze = 1'b1;
        rd(0, 8'h06, "R6");
        rd(0, 8'h06, "R6");
        chk_irq(1'b1, "R6");
        // R8 freeze without enable does not stop counting
        pulse(1);
        rd(3, 8'h05, "R8");
        freeze = 1'b0;
        rd(0, 8'h06, "R6");
        chk_irq(1'b0, "R6");
        rd(0, 8'h04, "R6");

        // R5 read-only flag
        wr(0, 8'h06);
        rd(0, 8'h04, "R5");
        chk_irq(1'b0, "R5");

        // R8 freeze with enable
        wr(0, 8'h0C);
        freeze = 1'b1;
        pulse(3);
        rd(3, 8'h05, "R8");
        freeze = 1'b0;
        pulse(1);
        rd(3, 8'h04, "R8");
        freeze = 1'b1;
        wr(0, 8'h0D);
        pulse(2);
        rd(0, 8'h0D, "R8");
        rd(3, 8'h04, "R8");
        freeze = 1'b0;
        pulse(1);
        rd(0, 8'h0C, "R4");
        rd(3, 8'h05, "R4");

        // R10 zero reload value
        wr(1, 8'h00);
        wr(0, 8'h09);
        pulse(1);
        rd(3, 8'h00, "R10");
        rd(0, 8'h0A, "R10");
        rd(0, 8'h08, "R10");
        pulse(1);
        rd(3, 8'h00, "R10");
        rd(0, 8'h0A, "R10");
        chk_irq(1'b0, "R7");

        cyc();
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard actual=%0d expected=0 pending reads", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule